// File: doc/BRIEF.md
# BCH Error-Location Correction Applier

This block sits between a BCH error locator and the sector buffers of a flash read path. It handles one 512-byte sector together with its ECC bytes. Two code strengths are supported: an 8-bit-correcting mode that uses 13 ECC bytes out of a 14-byte slot, and a 16-bit-correcting mode that uses 26 ECC bytes. When a sector starts, the block screens the computed syndrome. An all-zero syndrome means the sector is clean. An all-0xFF stored ECC means the sector is erased. A location count above the mode's strength means the sector cannot be corrected. In all three cases the sector finishes at once, and no location is processed.

At the same start event the block latches a byte-reversed copy of the syndrome for the locator. After that it takes error bit locations, one per clock. Each location is mirrored onto a byte and bit position across data plus ECC. The block then flips that bit through a byte-addressed buffer port. The read on that port is combinational and the write takes effect at the clock edge. Locations that fall outside the sector are flagged. At the end the block pulses a done flag and reports how many bits it corrected.

Top module: `bch_fix_applier`

## Requirements
- R1: After reset, done_o, busy_o, buf_we_o, fixed_cnt_o, bad_loc_o, uncorr_o, clean_o, erased_o and syn_o are all zero.
- R2: When start_i is taken while idle and every used computed ECC byte is zero, clean_o is 1 and done_o pulses in the next cycle with no write. The used bytes are 0..12 for mode 0 and 0..25 for mode 1; byte k sits at bits [8k+7:8k]. The reserved byte 13 of mode 0 is ignored. Clean takes priority over R3 and R10.
- R3: When the computed ECC is non-zero and every used stored ECC byte is 0xFF, erased_o is 1 and done_o pulses in the next cycle with no write. Erased takes priority over R10.
- R4: A start taken while idle latches syn_o. In mode 1, output byte k equals computed byte 25-k. In mode 0, output byte k equals computed byte 12-k for k<13, and output bytes 13..25 are 0x00. syn_o stays stable while busy.
- R5: For location L, the limit is 512 plus the used byte count (525 or 538). The byte position is limit-1-floor(L/8) and the bit is L mod 8.
- R6: A byte position below 512 writes buf_wdata_o = buf_rdata_i XOR (1<<bit) in the same cycle as loc_valid_i. In that cycle buf_ecc_sel_o=0 and buf_addr_o is the position.
- R7: A byte position from 512 up to limit-1 performs the same flip in the ECC buffer, with buf_ecc_sel_o=1 and buf_addr_o equal to the position minus 512.
- R8: A location with floor(L/8) >= limit causes no write. bad_loc_o is 1 when the sector finishes.
- R9: fixed_cnt_o equals the number of in-range locations applied. done_o is a one-cycle pulse in the cycle after the last counted location. A loc_cnt_i of 0 finishes one cycle after start with a count of 0.
- R10: When loc_cnt_i exceeds the strength (8 in mode 0, 16 in mode 1), uncorr_o is 1 and done_o pulses in the next cycle with no write.
- R11: Locations are taken only while busy_o is 1, one per cycle in which loc_valid_i is 1, and exactly loc_cnt_i of them are taken. start_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sector (taken when idle) |
| mode_i | input | 1 | 0: 8-bit strength, 13 ECC bytes; 1: 16-bit strength, 26 ECC bytes |
| loc_cnt_i | input | 5 | Number of locations the locator will deliver |
| calc_ecc_i | input | 208 | Computed ECC, byte k at [8k+7:8k] |
| stored_ecc_i | input | 208 | ECC read from the spare area, same layout |
| loc_valid_i | input | 1 | A location is present on loc_i |
| loc_i | input | 13 | Error bit location |
| buf_rdata_i | input | 8 | Combinational read data of the addressed buffer byte |
| syn_o | output | 208 | Byte-reversed syndrome for the locator |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_ecc_sel_o | output | 1 | 0: data buffer, 1: ECC buffer |
| buf_addr_o | output | 10 | Byte address inside the selected buffer |
| buf_wdata_o | output | 8 | Corrected byte |
| busy_o | output | 1 | Locations are being accepted |
| done_o | output | 1 | One-cycle end-of-sector pulse |
| fixed_cnt_o | output | 5 | Bits corrected in the last sector |
| bad_loc_o | output | 1 | A location fell outside data plus ECC |
| uncorr_o | output | 1 | Too many locations for the mode |
| clean_o | output | 1 | Computed syndrome was zero |
| erased_o | output | 1 | Stored ECC was all 0xFF |

## Verification
Some properties are checked by assertions on every cycle. Writes happen only while busy, and each write differs from the read byte in exactly one bit. ECC-side addresses stay below the used byte count. The reserved syndrome byte stays zero in the 8-bit mode, and the syndrome holds still during a run. The clean, erased and uncorrectable flags are mutually exclusive and never coexist with busy. The count never exceeds the strength, and done is a single pulse. Other behaviour can only be shown by the bench's scenarios against its reference model: the mirrored byte and bit mapping at both boundaries of each mode, a location that is valid in one mode but invalid in the other, repeated flips of one bit, the priority between the screening outcomes, and locations ignored after the sector finishes or while a second start arrives mid-run.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
   typedef enum logic {
      MODE_T8  = 1'b0,
      MODE_T16 = 1'b1
   } bch_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fix_state_e;
endpackage

// File: rtl/bchfix_screen.sv
module bchfix_screen
   import bchfix_pkg::*;
#(
   parameter int ECC_LO = 13,
   parameter int ECC_HI = 26
) (
   input  bch_mode_e             mode_i,
   input  logic [ECC_HI*8-1:0]   calc_i,
   input  logic [ECC_HI*8-1:0]   stored_i,
   output logic                  calc_zero_o,
   output logic                  stored_blank_o,
   output logic [ECC_HI*8-1:0]   syn_o
);
   logic [ECC_HI-1:0] nz_b;
   logic [ECC_HI-1:0] ff_b;
   logic [ECC_HI-1:0] use_b;
   logic              wide;

   assign wide = (mode_i == MODE_T16);

   for (genvar i = 0; i < ECC_HI; i++) begin : g_byte
      logic [7:0] short_b;
      assign use_b[i] = wide | (i < ECC_LO);
      assign nz_b[i]  = |calc_i[8*i +: 8];
      assign ff_b[i]  = &stored_i[8*i +: 8];
      if (i < ECC_LO) begin : g_lo
         assign short_b = calc_i[8*(ECC_LO-1-i) +: 8];
      end else begin : g_pad
         assign short_b = 8'h00;
      end
      assign syn_o[8*i +: 8] = wide ? calc_i[8*(ECC_HI-1-i) +: 8] : short_b;
   end

   assign calc_zero_o    = ~|(nz_b & use_b);
   assign stored_blank_o = &(ff_b | ~use_b);
endmodule

// File: rtl/bchfix_locmap.sv
module bchfix_locmap
   import bchfix_pkg::*;
#(
   parameter int SECT_BYTES = 512,
   parameter int ECC_LO     = 13,
   parameter int ECC_HI     = 26,
   parameter int ADDR_W     = 10,
   parameter int LOC_W      = ADDR_W + 3
) (
   input  bch_mode_e          mode_i,
   input  logic [LOC_W-1:0]   loc_i,
   output logic               hit_data_o,
   output logic               hit_ecc_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [7:0]         mask_o
);
   localparam logic [ADDR_W-1:0] LIM_LO = ADDR_W'(SECT_BYTES + ECC_LO);
   localparam logic [ADDR_W-1:0] LIM_HI = ADDR_W'(SECT_BYTES + ECC_HI);
   localparam logic [ADDR_W-1:0] SECT_A = ADDR_W'(SECT_BYTES);

   logic [ADDR_W-1:0] limit, boff, pos, rel;
   logic              in_rng, in_data;

   always_comb begin
      limit   = (mode_i == MODE_T16) ? LIM_HI : LIM_LO;
      boff    = loc_i[LOC_W-1:3];
      in_rng  = boff < limit;
      pos     = limit - boff - ADDR_W'(1);
      in_data = pos < SECT_A;
      rel     = pos - SECT_A;
      hit_data_o = in_rng & in_data;
      hit_ecc_o  = in_rng & ~in_data;
      addr_o     = in_data ? pos : rel;
      mask_o     = 8'h01 << loc_i[2:0];
   end
endmodule

// File: rtl/bchfix_ctrl.sv
module bchfix_ctrl
   import bchfix_pkg::*;
#(
   parameter int T_LO  = 8,
   parameter int T_HI  = 16,
   parameter int CNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  bch_mode_e         mode_i,
   input  logic              calc_zero_i,
   input  logic              stored_blank_i,
   input  logic [CNT_W-1:0]  loc_cnt_i,
   input  logic              loc_valid_i,
   input  logic              loc_ok_i,
   output logic              accept_o,
   output logic              busy_o,
   output bch_mode_e         mode_q_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  fixed_cnt_o,
   output logic              bad_loc_o,
   output logic              uncorr_o,
   output logic              clean_o,
   output logic              erased_o
);
   localparam logic [CNT_W-1:0] STR_LO = CNT_W'(T_LO);
   localparam logic [CNT_W-1:0] STR_HI = CNT_W'(T_HI);

   fix_state_e       state_q;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] strength;
   logic             over, finish_now;

   assign busy_o     = (state_q == ST_RUN);
   assign accept_o   = start_i & ~busy_o;
   assign strength   = (mode_i == MODE_T16) ? STR_HI : STR_LO;
   assign over       = loc_cnt_i > strength;
   assign finish_now = calc_zero_i | stored_blank_i | over | (loc_cnt_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         left_q      <= '0;
         mode_q_o    <= MODE_T8;
         done_o      <= 1'b0;
         fixed_cnt_o <= '0;
         bad_loc_o   <= 1'b0;
         uncorr_o    <= 1'b0;
         clean_o     <= 1'b0;
         erased_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (start_i) begin
               mode_q_o    <= mode_i;
               clean_o     <= calc_zero_i;
               erased_o    <= ~calc_zero_i & stored_blank_i;
               uncorr_o    <= ~calc_zero_i & ~stored_blank_i & over;
               fixed_cnt_o <= '0;
               bad_loc_o   <= 1'b0;
               if (finish_now) begin
                  done_o <= 1'b1;
               end else begin
                  state_q <= ST_RUN;
                  left_q  <= loc_cnt_i;
               end
            end
         end else if (loc_valid_i) begin
            if (loc_ok_i) fixed_cnt_o <= fixed_cnt_o + CNT_W'(1);
            else          bad_loc_o   <= 1'b1;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               state_q <= ST_IDLE;
               done_o  <= 1'b1;
            end
         end
      end
   end

   // R9: the corrected count never exceeds the strength of the latched mode
   assert_fixed_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_cnt_o <= ((mode_q_o == MODE_T16) ? STR_HI : STR_LO));

   // R9: done is a single-cycle pulse unless a new start arrives
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R10 (with R2, R3): screening outcomes are mutually exclusive
   assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clean_o, erased_o, uncorr_o}));

   // R2 (with R3, R10): a screened sector never enters the run state
   assert_skip_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_o || erased_o || uncorr_o) |-> !busy_o);
endmodule

// File: rtl/bch_fix_applier.sv
module bch_fix_applier
   import bchfix_pkg::*;
#(
   parameter int SECT_BYTES = 512,
   parameter int ECC_LO     = 13,
   parameter int ECC_HI     = 26,
   parameter int T_LO       = 8,
   parameter int T_HI       = 16,
   parameter int CNT_W      = 5,
   localparam int SYN_W     = 8 * ECC_HI,
   localparam int ADDR_W    = $clog2(SECT_BYTES + ECC_HI + 1),
   localparam int LOC_W     = ADDR_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [CNT_W-1:0]  loc_cnt_i,
   input  logic [SYN_W-1:0]  calc_ecc_i,
   input  logic [SYN_W-1:0]  stored_ecc_i,
   input  logic              loc_valid_i,
   input  logic [LOC_W-1:0]  loc_i,
   input  logic [7:0]        buf_rdata_i,
   output logic [SYN_W-1:0]  syn_o,
   output logic              buf_we_o,
   output logic              buf_ecc_sel_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic [7:0]        buf_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  fixed_cnt_o,
   output logic              bad_loc_o,
   output logic              uncorr_o,
   output logic              clean_o,
   output logic              erased_o
);
   if (ECC_LO + 1 > ECC_HI) begin : g_chk_slot
      $error("short mode needs a reserved byte inside the wide ECC slot");
   end
   if (T_LO >= T_HI) begin : g_chk_str
      $error("strengths must be ordered");
   end
   if (T_HI >= (1 << CNT_W)) begin : g_chk_cnt
      $error("count width too small for the strength");
   end

   bch_mode_e        mode_in, mode_q;
   logic [SYN_W-1:0] syn_comb;
   logic             calc_zero, stored_blank, accept;
   logic             hit_data, hit_ecc;
   logic [ADDR_W-1:0] addr;
   logic [7:0]       mask;

   assign mode_in = bch_mode_e'(mode_i);

   bchfix_screen #(.ECC_LO(ECC_LO), .ECC_HI(ECC_HI)) u_screen (
      .mode_i         (mode_in),
      .calc_i         (calc_ecc_i),
      .stored_i       (stored_ecc_i),
      .calc_zero_o    (calc_zero),
      .stored_blank_o (stored_blank),
      .syn_o          (syn_comb)
   );

   bchfix_locmap #(
      .SECT_BYTES (SECT_BYTES), .ECC_LO(ECC_LO), .ECC_HI(ECC_HI),
      .ADDR_W     (ADDR_W),     .LOC_W (LOC_W)
   ) u_map (
      .mode_i     (mode_q),
      .loc_i      (loc_i),
      .hit_data_o (hit_data),
      .hit_ecc_o  (hit_ecc),
      .addr_o     (addr),
      .mask_o     (mask)
   );

   bchfix_ctrl #(.T_LO(T_LO), .T_HI(T_HI), .CNT_W(CNT_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .mode_i         (mode_in),
      .calc_zero_i    (calc_zero),
      .stored_blank_i (stored_blank),
      .loc_cnt_i      (loc_cnt_i),
      .loc_valid_i    (loc_valid_i),
      .loc_ok_i       (hit_data | hit_ecc),
      .accept_o       (accept),
      .busy_o         (busy_o),
      .mode_q_o       (mode_q),
      .done_o         (done_o),
      .fixed_cnt_o    (fixed_cnt_o),
      .bad_loc_o      (bad_loc_o),
      .uncorr_o       (uncorr_o),
      .clean_o        (clean_o),
      .erased_o       (erased_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      syn_o <= '0;
      else if (accept) syn_o <= syn_comb;
   end

   assign buf_we_o      = busy_o & loc_valid_i & (hit_data | hit_ecc);
   assign buf_ecc_sel_o = hit_ecc;
   assign buf_addr_o    = addr;
   assign buf_wdata_o   = buf_rdata_i ^ mask;

   // R11: the buffer is written only during a run
   assert_write_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> busy_o);

   // R6: every write changes exactly one bit of the byte read
   assert_single_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> ($countones(buf_wdata_o ^ buf_rdata_i) == 1));

   // R7: ECC-side writes stay inside the used ECC bytes
   assert_ecc_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we_o && buf_ecc_sel_o) |->
         (buf_addr_o < ((mode_q == MODE_T16) ? ADDR_W'(ECC_HI) : ADDR_W'(ECC_LO))));

   // R4: the reserved byte of the short mode is always zero
   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_T8) |-> (syn_o[8*ECC_LO +: 8] == 8'h00));

   // R4: syndrome holds during a run
   assert_syn_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(syn_o));
endmodule

// File: tb/bch_fix_applier_tb.sv
`timescale 1ns/1ps
module bch_fix_applier_tb;
   localparam int SB = 512, EL = 13, EH = 26, SYNW = 8*EH, AW = 10, LOCW = 13, CW = 5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            start = 1'b0, mode = 1'b0, loc_valid = 1'b0;
   logic [CW-1:0]   loc_cnt = '0;
   logic [SYNW-1:0] calc = '0, stored = '0;
   logic [LOCW-1:0] loc = '0;
   logic [7:0]      buf_rdata;
   logic [SYNW-1:0] syn;
   logic            buf_we, buf_sel, busy, done, bad, unc, clean, erased;
   logic [AW-1:0]   buf_addr;
   logic [7:0]      buf_wdata;
   logic [CW-1:0]   fixed;

   bch_fix_applier u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .loc_cnt_i(loc_cnt),
      .calc_ecc_i(calc), .stored_ecc_i(stored), .loc_valid_i(loc_valid), .loc_i(loc),
      .buf_rdata_i(buf_rdata), .syn_o(syn), .buf_we_o(buf_we), .buf_ecc_sel_o(buf_sel),
      .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata), .busy_o(busy), .done_o(done),
      .fixed_cnt_o(fixed), .bad_loc_o(bad), .uncorr_o(unc), .clean_o(clean), .erased_o(erased)
   );

   logic [7:0] dmem [SB];
   logic [7:0] emem [32];
   logic [7:0] xdmem [SB];
   logic [7:0] xemem [32];

   assign buf_rdata = buf_sel ? emem[buf_addr[4:0]] : dmem[buf_addr[8:0]];
   always @(posedge clk) begin
      if (buf_we) begin
         if (buf_sel) emem[buf_addr[4:0]] <= buf_wdata;
         else         dmem[buf_addr[8:0]] <= buf_wdata;
      end
   end

   int n_chk = 0, n_fail = 0, cyc = 0;
   int locs [32];

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // reference model state
   logic            m_busy, m_mode, m_done, m_bad, m_unc, m_clean, m_erased;
   int              m_left, m_fixed;
   logic [SYNW-1:0] m_syn;
   int              lim, bo, pos, used, strn;
   logic            e_we, e_sel, z, ff;
   int              e_addr, e_bit;
   logic [7:0]      e_wdata;

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
      if (!rst_n) begin
         m_busy = 0; m_mode = 0; m_done = 0; m_bad = 0; m_unc = 0; m_clean = 0;
         m_erased = 0; m_left = 0; m_fixed = 0; m_syn = '0;
      end else begin
         // expected combinational write for this cycle
         e_we = 0; e_sel = 0; e_addr = 0; e_bit = 0; e_wdata = 8'h00;
         if (m_busy && loc_valid) begin
            lim = SB + (m_mode ? EH : EL);
            bo  = int'(loc) / 8;
            e_bit = int'(loc) % 8;
            if (bo < lim) begin
               pos = lim - 1 - bo;
               e_we = 1;
               if (pos < SB) begin e_sel = 0; e_addr = pos; e_wdata = xdmem[pos] ^ (8'h01 << e_bit); end
               else begin e_sel = 1; e_addr = pos - SB; e_wdata = xemem[pos - SB] ^ (8'h01 << e_bit); end
            end
         end
         chk(m_busy ? "R6 write strobe" : "R11 write strobe while idle", buf_we, e_we);
         if (e_we && buf_we) begin
            chk("R5 byte address", buf_addr, e_addr);
            chk("R7 buffer select", buf_sel, e_sel);
            chk("R6 corrected byte", buf_wdata, e_wdata);
         end
         chk("R9 done", done, m_done);
         chk("R9 fixed count", fixed, m_fixed);
         chk("R8 bad location", bad, m_bad);
         chk("R10 uncorrectable", unc, m_unc);
         chk("R2 clean", clean, m_clean);
         chk("R3 erased", erased, m_erased);
         chk("R4 syndrome", syn, m_syn);
         chk("R11 busy", busy, m_busy);
         // advance the model to the next clock edge
         m_done = 0;
         if (m_busy) begin
            if (loc_valid) begin
               if (e_we) begin
                  m_fixed++;
                  if (e_sel) xemem[e_addr] = e_wdata; else xdmem[e_addr] = e_wdata;
               end else m_bad = 1;
               m_left--;
               if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end
         end else if (start) begin
            m_mode = mode;
            used = mode ? EH : EL;
            strn = mode ? 16 : 8;
            z = 1; ff = 1;
            for (int k = 0; k < used; k++) begin
               if (calc[8*k +: 8] != 8'h00) z = 0;
               if (stored[8*k +: 8] != 8'hFF) ff = 0;
            end
            for (int k = 0; k < EH; k++) begin
               if (mode)        m_syn[8*k +: 8] = calc[8*(EH-1-k) +: 8];
               else if (k < EL) m_syn[8*k +: 8] = calc[8*(EL-1-k) +: 8];
               else             m_syn[8*k +: 8] = 8'h00;
            end
            m_clean  = z;
            m_erased = !z && ff;
            m_unc    = !z && !ff && (int'(loc_cnt) > strn);
            m_fixed  = 0; m_bad = 0;
            if (z || ff || int'(loc_cnt) > strn || loc_cnt == 0) m_done = 1;
            else begin m_busy = 1; m_left = int'(loc_cnt); end
         end
      end
   end

   function automatic logic [SYNW-1:0] pat(input int seed);
      logic [SYNW-1:0] v;
      for (int k = 0; k < EH; k++) v[8*k +: 8] = 8'(k*29 + seed*13 + 1);
      return v;
   endfunction

   task automatic mem_check(input string tag);
      int md = 0, me = 0;
      for (int i = 0; i < SB; i++) if (dmem[i] !== xdmem[i]) md++;
      for (int i = 0; i < 32; i++) if (emem[i] !== xemem[i]) me++;
      chk({tag, " R6 data buffer mismatches"}, md, 0);
      chk({tag, " R7 ECC buffer mismatches"}, me, 0);
   endtask

   task automatic run_sector(input logic md, input logic [SYNW-1:0] c, input logic [SYNW-1:0] s,
                             input int cnt, input int nstream, input int gap, input bit mid_start,
                             input string tag);
      @(posedge clk); #1;
      mode = md; calc = c; stored = s; loc_cnt = CW'(cnt); start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int i = 0; i < nstream; i++) begin
         loc = LOCW'(locs[i]); loc_valid = 1'b1;
         if (mid_start && i == 1) begin start = 1'b1; mode = ~md; end
         @(posedge clk); #1;
         loc_valid = 1'b0; start = 1'b0; mode = md;
         repeat (gap) begin @(posedge clk); #1; end
      end
      repeat (4) @(posedge clk);
      #1;
      mem_check(tag);
   endtask

   logic [SYNW-1:0] cv, sv;

   initial begin
      for (int i = 0; i < SB; i++) begin dmem[i] = 8'(i*7 + 3); xdmem[i] = 8'(i*7 + 3); end
      for (int i = 0; i < 32; i++) begin emem[i] = 8'(i*11 + 5); xemem[i] = 8'(i*11 + 5); end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 done after reset", done, 0);
      chk("R1 busy after reset", busy, 0);
      chk("R1 write after reset", buf_we, 0);
      chk("R1 count after reset", fixed, 0);
      chk("R1 flags after reset", {bad, unc, clean, erased}, 0);
      chk("R1 syndrome after reset", syn, 0);

      // R2: clean sector, reserved byte 13 of mode 0 ignored, locations ignored
      cv = '0; cv[8*13 +: 8] = 8'hA5;
      locs[0] = 5; locs[1] = 6; locs[2] = 7;
      run_sector(1'b0, cv, pat(3), 3, 3, 0, 0, "R2 clean");

      // R3: erased sector in mode 1
      locs[0] = 9; locs[1] = 10;
      run_sector(1'b1, pat(1), {SYNW{1'b1}}, 2, 2, 0, 0, "R3 erased wide");

      // R3: erased over used bytes only in mode 0
      sv = pat(9); sv[0 +: 8*EL] = {(8*EL){1'b1}};
      run_sector(1'b0, pat(2), sv, 2, 2, 0, 0, "R3 erased short");

      // R5 R6 R7 R8: mode 0 boundaries with gaps
      locs[0] = 0; locs[1] = 103; locs[2] = 104; locs[3] = 4199; locs[4] = 4200;
      run_sector(1'b0, pat(4), pat(5), 5, 5, 1, 0, "R5 short boundaries");

      // R5 R9 R11: mode 1 full strength, repeated bit, mid-run start, extra locations
      locs[0] = 0;    locs[1] = 207;  locs[2] = 208;  locs[3] = 4303;
      locs[4] = 208;  locs[5] = 1000; locs[6] = 1500; locs[7] = 2000;
      locs[8] = 2500; locs[9] = 3000; locs[10] = 3500; locs[11] = 4100;
      locs[12] = 4250; locs[13] = 4300; locs[14] = 50; locs[15] = 9;
      locs[16] = 300; locs[17] = 301;
      run_sector(1'b1, pat(6), pat(7), 16, 18, 0, 1, "R9 wide full");

      // R10: too many locations in each mode
      locs[0] = 12; locs[1] = 13;
      run_sector(1'b1, pat(8), pat(10), 17, 2, 0, 0, "R10 wide over");
      run_sector(1'b0, pat(11), pat(12), 9, 1, 0, 0, "R10 short over");

      // R9: exactly the strength in mode 0
      locs[0] = 1; locs[1] = 2; locs[2] = 3; locs[3] = 4;
      locs[4] = 4199; locs[5] = 100; locs[6] = 4000; locs[7] = 3;
      run_sector(1'b0, pat(15), pat(16), 8, 8, 2, 0, "R9 short full");

      // R9: zero locations with a non-zero syndrome
      locs[0] = 77;
      run_sector(1'b0, pat(13), pat(14), 0, 1, 0, 0, "R9 empty");

      // R8: location valid only in mode 1, used in mode 0
      locs[0] = 4250; locs[1] = 16;
      run_sector(1'b0, pat(17), pat(18), 2, 2, 0, 0, "R8 short range");

      // R2: clean takes priority over R10 in mode 1
      locs[0] = 40;
      run_sector(1'b1, '0, pat(19), 20, 1, 0, 0, "R2 clean priority");

      repeat (3) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule